// File: doc/BRIEF.md
# I2C SCL Tap-Based Clock Divider

This block produces the bit timing for an I2C controller from the system clock. An 8-bit divider code sets the timing. The code holds three fields: a prescale field, a tap-spacing field and a tap-select field. Each field picks entries from a small fixed table, and a fixed formula combines those entries into three values:

- the SCL period;
- a hold count used for START and STOP timing;
- the point where SDA may change after SCL goes low.

The code allows 256 settings. The resulting period does not grow smoothly with the code.

Each restart pulse latches the divider code and begins a new SCL period. The period begins with the SCL falling edge. The block then repeats that period until another restart arrives or the enable is dropped.

The outputs are single-cycle strobes for three events: SCL falling, SCL rising and the SDA-change point. There is also a level that shows the phase of SCL. The computed period and hold counts are brought out so that a neighbour or a checker can read them. Driving the bus pins and sequencing the protocol belong to other blocks.

Top module: `i2c_scl_divider`

## Requirements
- R1: After reset all three strobes are low and `scl_hi` is 1. The latched code is 0, so `div_count` reads 16 and `hold_count` reads 12.
- R2: Code bits [7:6] select the prescale factor: 00 gives 1, 01 gives 2, 10 gives 4. The value 11 also gives 4.
- R3: Code bits [2:0] select the pair (SCL tap, SDA tap): 000→(5,1), 001→(6,1), 010→(7,2), 011→(8,2), 100→(9,3), 101→(10,3), 110→(12,4), 111→(15,4).
- R4: Code bits [5:3] select the pair (edge offset, tap spacing): 000→(5,1), 001→(6,2), 010→(6,4), 011→(6,8), 100→(6,16), 101→(14,32), 110→(30,64), 111→(126,128).
- R5: `div_count` equals prescale × (2·offset + (SCL tap − 1)·spacing + 2).
- R6: `hold_count` equals prescale × (offset + (SCL tap − 1)·spacing + 3).
- R7: While enabled, `scl_fall` pulses for one cycle in the cycle after a restart is sampled. It then pulses again every `div_count` cycles.
- R8: `scl_rise` pulses floor(`div_count`/2) cycles after each `scl_fall`. `scl_hi` is 0 from the fall up to the rise and 1 from the rise onward.
- R9: `sda_chg` pulses prescale × SDA tap × spacing cycles after each `scl_fall`. At most one of the three strobes is high in any cycle.
- R10: A change of `div_code` without a restart has no effect on any output. The new code takes effect from the next restart.
- R11: While `en` is 0, the timing stops. No strobe fires, `scl_hi` is 1, and a restart is ignored.
- R12: A restart in the middle of a period abandons that period. The next cycle shows `scl_fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the timing; when low, the timing is held in its idle state |
| restart | input | 1 | Pulse that latches the code and begins a new period |
| div_code | input | 8 | Divider code: [7:6] prescale, [5:3] spacing, [2:0] tap |
| scl_fall | output | 1 | Strobe marking the SCL falling edge |
| scl_rise | output | 1 | Strobe marking the SCL rising edge |
| sda_chg | output | 1 | Strobe marking the SDA change point |
| scl_hi | output | 1 | SCL phase: 0 in the low half, 1 in the high half or when idle |
| div_count | output | CNT_W | SCL period in system clocks for the latched code |
| hold_count | output | CNT_W | START/STOP hold count for the latched code |

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

## Verification
The bench builds the block with the default `CNT_W` of 13. That width holds the longest period of 8184 clocks and the largest hold count of 7684, so every code can be used without truncation.

- **Counts:** for all 256 codes, the bench checks `div_count` and `hold_count` against the formulas.
- **Strobe timing:** for all 64 codes with prescale 1, and for a sample of codes at prescale 2 and 4 including the reserved value, the bench times the rise, SDA-change and next-fall strobes cycle by cycle.
- **Control behaviour:** separate sequences cover a code change without a restart, a restart in mid-period, and operation with the enable low.

// File: rtl/i2c_div_pkg.sv
package i2c_div_pkg;
  localparam int TAP_W = 4;
  localparam int SDA_W = 3;
  localparam int OFS_W = 7;
  localparam int SPC_W = 8;
  localparam int PRE_W = 3;

  typedef struct packed {
    logic [PRE_W-1:0] prescale;
    logic [TAP_W-1:0] scl_tap;
    logic [SDA_W-1:0] sda_tap;
    logic [OFS_W-1:0] edge_ofs;
    logic [SPC_W-1:0] spacing;
  } tap_set_t;
endpackage

// File: rtl/i2c_div_lookup.sv
module i2c_div_lookup
  import i2c_div_pkg::*;
(
  input  logic [7:0] code,
  output tap_set_t   taps
);
  logic [1:0] pre_f;
  logic [2:0] spc_f;
  logic [2:0] tap_f;

  assign pre_f = code[7:6];
  assign spc_f = code[5:3];
  assign tap_f = code[2:0];

  // Prescale select; the spare value maps to the largest factor (R2)
  always_comb begin
    unique case (pre_f)
      2'b00:   taps.prescale = 3'd1;
      2'b01:   taps.prescale = 3'd2;
      default: taps.prescale = 3'd4;
    endcase
  end

  // Tap-select pair (R3)
  always_comb begin
    unique case (tap_f)
      3'd0: begin taps.scl_tap = 4'd5;  taps.sda_tap = 3'd1; end
      3'd1: begin taps.scl_tap = 4'd6;  taps.sda_tap = 3'd1; end
      3'd2: begin taps.scl_tap = 4'd7;  taps.sda_tap = 3'd2; end
      3'd3: begin taps.scl_tap = 4'd8;  taps.sda_tap = 3'd2; end
      3'd4: begin taps.scl_tap = 4'd9;  taps.sda_tap = 3'd3; end
      3'd5: begin taps.scl_tap = 4'd10; taps.sda_tap = 3'd3; end
      3'd6: begin taps.scl_tap = 4'd12; taps.sda_tap = 3'd4; end
      default: begin taps.scl_tap = 4'd15; taps.sda_tap = 3'd4; end
    endcase
  end

  // Spacing pair; the spacing is a power of two (R4)
  always_comb begin
    taps.spacing = SPC_W'(1) << spc_f;
    unique case (spc_f)
      3'd0:    taps.edge_ofs = 7'd5;
      3'd5:    taps.edge_ofs = 7'd14;
      3'd6:    taps.edge_ofs = 7'd30;
      3'd7:    taps.edge_ofs = 7'd126;
      default: taps.edge_ofs = 7'd6;
    endcase
  end
endmodule

// File: rtl/i2c_div_calc.sv
module i2c_div_calc
  import i2c_div_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  tap_set_t         taps,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] hold,
  output logic [CNT_W-1:0] sda_dly
);
  logic [CNT_W-1:0] pre, st, sd, ofs, spc, span, core_p, core_h;

  assign pre  = CNT_W'(taps.prescale);
  assign st   = CNT_W'(taps.scl_tap);
  assign sd   = CNT_W'(taps.sda_tap);
  assign ofs  = CNT_W'(taps.edge_ofs);
  assign spc  = CNT_W'(taps.spacing);
  assign span = (st - CNT_W'(1)) * spc;

  assign core_p  = (ofs << 1) + span + CNT_W'(2);   // R5
  assign core_h  = ofs + span + CNT_W'(3);          // R6
  assign period  = pre * core_p;
  assign hold    = pre * core_h;
  assign sda_dly = pre * sd * spc;                  // R9
endmodule

// File: rtl/i2c_div_phase.sv
module i2c_div_phase #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] sda_dly,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             sda_chg,
  output logic             scl_hi
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             active;
  logic             last;

  assign half = period >> 1;
  assign last = (cnt == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

  assign scl_fall = active && (cnt == '0);
  assign scl_rise = active && (cnt == half);
  assign sda_chg  = active && (cnt == sda_dly);
  assign scl_hi   = !active || (cnt >= half);

  p_restart_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en && restart |=> scl_fall);
  p_wrap_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && !restart && active && last |=> scl_fall);
  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(scl_fall || scl_rise || sda_chg) && scl_hi);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, sda_chg}));
  p_fall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> !scl_hi);
  p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> scl_hi && $past(!scl_hi));
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2c_div_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [7:0]       div_code,
  output logic             scl_fall,
  output logic             scl_rise,
  output logic             sda_chg,
  output logic             scl_hi,
  output logic [CNT_W-1:0] div_count,
  output logic [CNT_W-1:0] hold_count
);
  logic [7:0]       code_q;
  tap_set_t         taps;
  logic [CNT_W-1:0] sda_dly;

  // The code is captured only on an accepted restart (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             code_q <= '0;
    else if (en && restart) code_q <= div_code;
  end

  i2c_div_lookup u_lookup (
    .code (code_q),
    .taps (taps)
  );

  i2c_div_calc #(.CNT_W(CNT_W)) u_calc (
    .taps    (taps),
    .period  (div_count),
    .hold    (hold_count),
    .sda_dly (sda_dly)
  );

  i2c_div_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .restart  (restart),
    .period   (div_count),
    .sda_dly  (sda_dly),
    .scl_fall (scl_fall),
    .scl_rise (scl_rise),
    .sda_chg  (sda_chg),
    .scl_hi   (scl_hi)
  );

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && restart) |=> $stable(div_count) && $stable(hold_count));
endmodule

// File: tb/sim_i2c_scl_divider.sv
module sim_i2c_scl_divider;
  localparam int CNT_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic restart = 1'b0;
  logic [7:0] div_code = 8'h00;
  logic scl_fall, scl_rise, sda_chg, scl_hi;
  logic [CNT_W-1:0] div_count, hold_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  i2c_scl_divider #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .div_code(div_code),
    .scl_fall(scl_fall), .scl_rise(scl_rise), .sda_chg(sda_chg), .scl_hi(scl_hi),
    .div_count(div_count), .hold_count(hold_count)
  );

  function automatic int e_pre(input logic [7:0] c);
    case (c[7:6]) 2'b00: return 1; 2'b01: return 2; default: return 4; endcase
  endfunction
  function automatic int e_st(input logic [7:0] c);
    case (c[2:0])
      0: return 5; 1: return 6; 2: return 7; 3: return 8;
      4: return 9; 5: return 10; 6: return 12; default: return 15;
    endcase
  endfunction
  function automatic int e_sd(input logic [7:0] c);
    case (c[2:0])
      0, 1: return 1; 2, 3: return 2; 4, 5: return 3; default: return 4;
    endcase
  endfunction
  function automatic int e_ofs(input logic [7:0] c);
    case (c[5:3])
      0: return 5; 5: return 14; 6: return 30; 7: return 126; default: return 6;
    endcase
  endfunction
  function automatic int e_spc(input logic [7:0] c);
    case (c[5:3])
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 16; 5: return 32; 6: return 64; default: return 128;
    endcase
  endfunction
  function automatic int e_per(input logic [7:0] c);
    return e_pre(c) * (2 * e_ofs(c) + (e_st(c) - 1) * e_spc(c) + 2);
  endfunction
  function automatic int e_hold(input logic [7:0] c);
    return e_pre(c) * (e_ofs(c) + (e_st(c) - 1) * e_spc(c) + 3);
  endfunction
  function automatic int e_sda(input logic [7:0] c);
    return e_pre(c) * e_sd(c) * e_spc(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Pulse a restart with code c; on return the fall strobe is visible
  task automatic kick(input logic [7:0] c);
    div_code = c;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // Times the strobes of one period starting at the current fall
  task automatic time_period(input logic [7:0] c, input string tag);
    int t_rise = -1, t_sda = -1, t_fall = -1, lo_bad = 0;
    chk(scl_fall === 1'b1, {tag, " R7 fall at start"}, int'(scl_fall), 1);
    for (int t = 1; t <= 9000 && t_fall < 0; t++) begin
      @(negedge clk);
      if (scl_rise && t_rise < 0) t_rise = t;
      if (sda_chg && t_sda < 0) t_sda = t;
      if (scl_fall) t_fall = t;
      if (t_rise < 0 && scl_hi) lo_bad++;
    end
    chk(t_fall == e_per(c), {tag, " R7 fall spacing"}, t_fall, e_per(c));
    chk(t_rise == e_per(c) / 2, {tag, " R8 rise offset"}, t_rise, e_per(c) / 2);
    chk(t_sda == e_sda(c), {tag, " R9 sda offset"}, t_sda, e_sda(c));
    chk(lo_bad == 0, {tag, " R8 scl low phase"}, lo_bad, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!scl_fall && !scl_rise && !sda_chg, "R1 strobes idle", int'(scl_fall | scl_rise | sda_chg), 0);
    chk(scl_hi === 1'b1, "R1 scl_hi", int'(scl_hi), 1);
    chk(div_count == 16, "R1 div_count", int'(div_count), 16);
    chk(hold_count == 12, "R1 hold_count", int'(hold_count), 12);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 counts for every code
    for (int c = 0; c < 256; c++) begin
      kick(8'(c));
      chk(int'(div_count) == e_per(8'(c)), "R5 R2 R3 R4 div_count", int'(div_count), e_per(8'(c)));
      chk(int'(hold_count) == e_hold(8'(c)), "R6 R2 R3 R4 hold_count", int'(hold_count), e_hold(8'(c)));
    end

    // R7 R8 R9 strobe timing, all prescale-1 codes
    for (int c = 0; c < 64; c++) begin
      kick(8'(c));
      time_period(8'(c), "sweep");
    end

    // Sample of codes at prescale 2, 4 and the spare value (R2)
    begin
      logic [7:0] smp [6] = '{8'h41, 8'h7F, 8'h8A, 8'hB5, 8'hC3, 8'hFF};
      for (int i = 0; i < 6; i++) begin
        kick(smp[i]);
        time_period(smp[i], "R2 sample");
      end
    end

    // R10 code change without restart has no effect
    kick(8'h12);
    div_code = 8'h3F;
    time_period(8'h12, "R10 held code");
    chk(int'(div_count) == e_per(8'h12), "R10 div_count held", int'(div_count), e_per(8'h12));
    kick(8'h3F);
    chk(int'(div_count) == e_per(8'h3F), "R10 new code at restart", int'(div_count), e_per(8'h3F));

    // R12 restart in mid-period
    repeat (40) @(negedge clk);
    kick(8'h09);
    chk(scl_fall === 1'b1, "R12 fall after mid restart", int'(scl_fall), 1);
    time_period(8'h09, "R12 fresh period");

    // R11 disabled: no strobes, restart ignored
    begin
      int seen = 0;
      int lows = 0;
      en = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 60; i++) begin
        if (i == 20) restart = 1'b1;
        if (i == 21) restart = 1'b0;
        div_code = 8'h00;
        @(negedge clk);
        if (scl_fall || scl_rise || sda_chg) seen++;
        if (!scl_hi) lows++;
      end
      chk(seen == 0, "R11 no strobes while off", seen, 0);
      chk(lows == 0, "R11 scl_hi while off", lows, 0);
      chk(int'(div_count) == e_per(8'h09), "R11 restart ignored", int'(div_count), e_per(8'h09));
    end

    summary();
  end
endmodule